// File: doc/BRIEF.md
# Interrupt Return Frame Unwinder

This block unwinds an interrupt stack frame when a return from an interrupt is requested. It takes a one-cycle request together with the current stack pointer, the execution mode, the operand size and the current privilege level. It then reads the frame from memory, one read per cycle, at addresses that rise by the pop width. When the frame has been consumed it presents the restored instruction pointer, code selector and flags word. If the frame carries the outer stack pair, it also presents the restored stack selector and stack pointer. A single-cycle done pulse marks the result.

In 64-bit mode every item is 8 bytes wide and the outer pair is always unwound. In compatibility and legacy modes the item width comes from the operand size. In those modes the outer pair is unwound only when the popped code selector shows a return to a less privileged level. The memory port has a fixed latency: read data is valid in the cycle after the read was issued. Descriptor checks, segment loading and fault generation belong to neighbouring logic.

Top module: `iret_unwinder`

## Requirements
- R1: After reset `done` and `rd_en` are low, and they stay low until a request is accepted.
- R2: With `mode` 2 or 3 (64-bit), every item is 8 bytes wide, whatever the value of `opsize`.
- R3: With `mode` 0 (legacy) or 1 (compatibility), the item width follows `opsize`: 0 gives 2 bytes, 1 gives 4 bytes, and 2 or 3 give 8 bytes.
- R4: Reads are issued in consecutive cycles in this order: instruction pointer, code selector, flags, stack pointer, stack selector. The address of read k is `sp_in + k*width`, and the data for each read arrives on the next cycle.
- R5: In 64-bit mode the stack pointer and stack selector are always popped, giving five reads and `out_outer` = 1.
- R6: In legacy and compatibility modes the outer pair is popped exactly when bits [1:0] of the popped code selector are numerically greater than `cpl`.
- R7: When the outer pair is popped, `out_sp` is the popped value unchanged, including any misalignment.
- R8: When the outer pair is not popped, `out_sp` = `sp_in + 3*width`, `out_ss` = 0, and only three reads are issued.
- R9: Every popped item is zero-extended from the item width. `out_cs` and `out_ss` take the low 16 bits of their items.
- R10: `done` is a one-cycle pulse. It is high on the 5th cycle after the accepting edge with three reads, and on the 7th with five. The outputs are valid while it is high.
- R11: A request that arrives while a frame is being unwound is ignored, and it produces no extra reads and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Return request, one cycle |
| mode | input | 2 | 0 legacy, 1 compatibility, 2/3 64-bit |
| opsize | input | 2 | Operand size code: 0 = 2, 1 = 4, 2/3 = 8 bytes |
| cpl | input | 2 | Current privilege level |
| sp_in | input | AW | Stack pointer at the request |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | AW | Read byte address |
| rd_data | input | DW | Read data, valid the cycle after `rd_en` |
| done | output | 1 | Result valid pulse |
| out_ip | output | DW | Restored instruction pointer |
| out_cs | output | 16 | Restored code selector |
| out_flags | output | DW | Restored flags |
| out_sp | output | AW | Restored stack pointer |
| out_ss | output | 16 | Restored stack selector, 0 if not popped |
| out_outer | output | 1 | Outer pair was popped |

## Verification
The assertions check on every cycle that `done` lasts one cycle and never coincides with a read. They check that back-to-back reads step by 2, 4 or 8 bytes and that no frame takes more than five reads. They also check that the captured request stays stable while busy. At each done pulse they check the outer-pair decision in 64-bit mode and against the selector's low bits, and that the stack selector is cleared when the pair is absent. Only the bench scenarios can show the exact values: the widths chosen per mode and operand size, the masked contents, the `sp_in + 3*width` result, the done latency, and that a request made while busy leaves the result unchanged.

// File: rtl/iret_unwinder.sv
module iret_unwinder #(
  parameter int AW = 64,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [1:0]    mode,
  input  logic [1:0]    opsize,
  input  logic [1:0]    cpl,
  input  logic [AW-1:0] sp_in,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic [DW-1:0] out_ip,
  output logic [15:0]   out_cs,
  output logic [DW-1:0] out_flags,
  output logic [AW-1:0] out_sp,
  output logic [15:0]   out_ss,
  output logic          out_outer
);

  logic          busy, long_q, outer_q, pend;
  logic [1:0]    wsel_q, cpl_q;
  logic [2:0]    iidx, ridx;
  logic [AW-1:0] sp_q, addr_q;
  logic [AW-1:0] wbytes;
  logic [DW-1:0] mask, item;
  logic          last_rx;

  assign wbytes  = AW'(2) << wsel_q;
  assign mask    = (wsel_q == 2'd2) ? {DW{1'b1}} : ((DW'(1) << (16 << wsel_q)) - DW'(1));
  assign item    = rd_data & mask;
  assign rd_en   = busy && ((iidx < 3'd3) || (outer_q && iidx < 3'd5));
  assign rd_addr = addr_q;
  assign last_rx = pend && (ridx == (outer_q ? 3'd4 : 3'd2));
  assign out_outer = outer_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; long_q <= 1'b0; outer_q <= 1'b0; pend <= 1'b0;
      wsel_q <= '0; cpl_q <= '0; iidx <= '0; ridx <= '0;
      sp_q <= '0; addr_q <= '0; done <= 1'b0;
      out_ip <= '0; out_cs <= '0; out_flags <= '0; out_sp <= '0; out_ss <= '0;
    end else begin
      done <= 1'b0;
      pend <= rd_en;
      if (!busy && req) begin
        busy    <= 1'b1;
        long_q  <= mode[1];
        wsel_q  <= (mode[1] || opsize == 2'd3) ? 2'd2 : opsize;
        cpl_q   <= cpl;
        sp_q    <= sp_in;
        addr_q  <= sp_in;
        iidx    <= '0;
        ridx    <= '0;
        outer_q <= 1'b0;
        out_ss  <= '0;
      end
      if (rd_en) begin
        iidx   <= iidx + 3'd1;
        addr_q <= addr_q + wbytes;
      end
      if (pend) begin
        ridx <= ridx + 3'd1;
        case (ridx)
          3'd0: out_ip <= item;
          3'd1: begin
            out_cs  <= item[15:0];
            outer_q <= long_q || (item[1:0] > cpl_q);
          end
          3'd2: begin
            out_flags <= item;
            if (!outer_q) out_sp <= sp_q + 3 * wbytes;
          end
          3'd3: out_sp <= AW'(item);
          default: out_ss <= item[15:0];
        endcase
      end
      if (last_rx) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

endmodule

module iret_unwinder_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          done,
  input logic          busy,
  input logic          long_q,
  input logic [1:0]    cpl_q,
  input logic [1:0]    wsel_q,
  input logic [15:0]   out_cs,
  input logic [15:0]   out_ss,
  input logic          out_outer
);

  logic [2:0] rcnt;
  always_ff @(posedge clk) begin
    if (!rst_n || done) rcnt <= '0;
    else if (rd_en) rcnt <= rcnt + 3'd1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) !(done && rd_en)); // R4
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> ((rd_addr - $past(rd_addr)) == AW'(2) || (rd_addr - $past(rd_addr)) == AW'(4)
                                 || (rd_addr - $past(rd_addr)) == AW'(8))); // R4
  AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> rcnt < 3'd5); // R4
  AST_LONG_OUTER: assert property (@(posedge clk) disable iff (!rst_n) (done && long_q) |-> out_outer); // R5
  AST_LONG_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (busy && long_q) |-> wsel_q == 2'd2); // R2
  AST_PRIV_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !long_q) |-> (out_outer == (out_cs[1:0] > cpl_q))); // R6
  AST_SS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) (done && !out_outer) |-> out_ss == 16'h0); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cpl_q) && $stable(wsel_q) && $stable(long_q))); // R11

endmodule

bind iret_unwinder iret_unwinder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .done(done),
  .busy(busy), .long_q(long_q), .cpl_q(cpl_q), .wsel_q(wsel_q),
  .out_cs(out_cs), .out_ss(out_ss), .out_outer(out_outer)
);

// File: tb/iret_unwinder_test.sv
module iret_unwinder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  mode = '0, opsize = '0, cpl = '0;
  logic [63:0] sp_in = '0;
  logic        rd_en;
  logic [63:0] rd_addr;
  logic [63:0] rd_data = '0;
  logic        done, out_outer;
  logic [63:0] out_ip, out_flags, out_sp;
  logic [15:0] out_cs, out_ss;

  int checks = 0, errors = 0;
  int rd_cnt = 0;
  logic [63:0] base = '0, wexp = 64'd8;
  logic [1:0]  rpl = '0;

  always #5 clk = ~clk;

  iret_unwinder uut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .opsize(opsize), .cpl(cpl),
    .sp_in(sp_in), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .done(done),
    .out_ip(out_ip), .out_cs(out_cs), .out_flags(out_flags), .out_sp(out_sp),
    .out_ss(out_ss), .out_outer(out_outer)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] frame(input int k);
    logic [63:0] v = 64'h8877_6655_4433_2210 + 64'(k) * 64'h0101_0101_0101_0101;
    if (k == 1) v = {v[63:2], rpl};
    return v;
  endfunction

  function automatic logic [63:0] wmask(input logic [63:0] w);
    return (w == 64'd8) ? '1 : ((64'd1 << (w * 8)) - 64'd1);
  endfunction

  always @(posedge clk) begin
    if (rst_n && rd_en) begin
      check("R4 read address", rd_addr, base + 64'(rd_cnt) * wexp);
      rd_data <= frame(rd_cnt);
      rd_cnt  <= rd_cnt + 1;
    end
  end

  localparam int NV = 9;
  localparam logic [39:0] VEC [NV] = '{
    {2'd2, 2'd0, 2'd0, 2'd0, 32'h0000_1000},
    {2'd3, 2'd1, 2'd3, 2'd3, 32'h0000_2008},
    {2'd1, 2'd2, 2'd0, 2'd3, 32'h0000_3010},
    {2'd1, 2'd2, 2'd3, 2'd3, 32'h0000_3ff8},
    {2'd0, 2'd1, 2'd0, 2'd0, 32'h0000_4004},
    {2'd0, 2'd1, 2'd1, 2'd2, 32'h0000_4100},
    {2'd0, 2'd0, 2'd0, 2'd3, 32'h0000_5002},
    {2'd0, 2'd3, 2'd2, 2'd1, 32'h0000_6000},
    {2'd1, 2'd0, 2'd2, 2'd2, 32'h0000_7006}
  };

  task automatic run(input logic [1:0] m, input logic [1:0] o, input logic [1:0] c,
                     input logic [1:0] r, input logic [63:0] sp, input bit poke);
    logic        outer;
    int          lat;
    logic [63:0] mk;
    @(negedge clk);
    mode = m; opsize = o; cpl = c; sp_in = sp; rpl = r; base = sp; rd_cnt = 0;
    wexp  = (m[1] || o == 2'd3) ? 64'd8 : (64'd2 << o);
    outer = m[1] || (r > c);
    mk    = wmask(wexp);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      if (poke && lat == 2) begin
        req = 1'b1; mode = 2'd0; opsize = 2'd0; cpl = 2'd3; sp_in = 64'hdead_0000;
      end else req = 1'b0;
      @(negedge clk);
      lat++;
    end
    req = 1'b0;
    check("R10 done latency", 64'(lat), outer ? 64'd7 : 64'd5);
    check("R2 R3 R9 out_ip", out_ip, frame(0) & mk);
    check("R4 R9 out_cs", {48'h0, out_cs}, {48'h0, frame(1)[15:0]});
    check("R4 R9 out_flags", out_flags, frame(2) & mk);
    check("R5 R6 out_outer", {63'h0, out_outer}, {63'h0, outer});
    check("R7 R8 out_sp", out_sp, outer ? (frame(3) & mk) : sp + 3 * wexp);
    check("R8 R9 out_ss", {48'h0, out_ss}, outer ? {48'h0, frame(4)[15:0]} : 64'h0);
    check("R4 R8 read count", 64'(rd_cnt), outer ? 64'd5 : 64'd3);
    @(negedge clk);
    check("R10 done one cycle", {63'h0, done}, 64'h0);
  endtask

  initial begin
    #200_000_0;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done at reset", {63'h0, done}, 64'h0);
    check("R1 rd_en at reset", {63'h0, rd_en}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", {62'h0, done, rd_en}, 64'h0);

    for (int i = 0; i < NV; i++)
      run(VEC[i][39:38], VEC[i][37:36], VEC[i][35:34], VEC[i][33:32], {32'h0, VEC[i][31:0]}, 1'b0);

    // R11: request while busy is ignored, and no second done follows
    run(2'd1, 2'd1, 2'd0, 2'd2, 64'h0000_8004, 1'b1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (done || rd_en) check("R11 no extra activity", {62'h0, done, rd_en}, 64'h0);
    end
    check("R11 read count after poke", 64'(rd_cnt), 64'd5);

    // R2: 64-bit mode with small operand size, unaligned pointer kept (R7)
    run(2'd2, 2'd0, 2'd3, 2'd3, 64'h0000_9003, 1'b0);
    // R6 boundary: equal levels, no pop
    run(2'd0, 2'd2, 2'd1, 2'd1, 64'h0000_a000, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule